// File: doc/BRIEF.md
# Two-Level Interrupt Acknowledge Unit

This block pairs two eight-input interrupt resolvers. The second (slave) resolver reports its winning request into input 2 of the first (master) resolver. The master's winner drives the processor interrupt request.

An acknowledge strobe from the processor samples the current winners and marks them in service. One cycle later the unit returns an 8-bit vector and a 4-bit global line number, together with a done pulse. When no genuine winner exists at acknowledge time, line 7 of the controller concerned is reported as a spurious interrupt.

A poll strobe takes the place of an acknowledge. It returns the winning line of one controller and retires that line completely. A non-specific end-of-interrupt strobe for each controller clears its highest-priority in-service bit. The vector bases and the masks come in as plain inputs; register decoding sits elsewhere.

Top module: `pic_cascade`

## Requirements
- R1: After reset, all outputs are zero. No request is pending and no line is in service.
- R2: A line records a request only on a 0-to-1 transition of its input. A line held high after being serviced does not request again.
- R3: Priority is fixed, with line 0 highest. A pending line wins only if no line of equal or higher priority is in service in that controller. A non-specific end-of-interrupt clears the highest-priority in-service bit.
- R4: A set mask bit keeps the matching pending line from winning, and the line stays pending. When the bit is cleared, the line can win.
- R5: `cpu_irq_o` is high exactly when the master has a winner. A slave winner sets master request 2 on the following clock edge. The external input at global line 2 has no effect.
- R6: An acknowledge while the master winner is a line other than 2 sets `done_o` on the next cycle. In that cycle `line_o` is that line, the line is marked in service and its request is cleared.
- R7: An acknowledge while the master winner is line 2 also acknowledges the slave winner. It returns vector = slave base with bits 2:0 cleared, plus the slave line, and `line_o` = slave line + 8.
- R8: If the master winner is 2 but the slave has no winner, the acknowledge returns `line_o` = 15 and vector = slave base with bits 2:0 set to 7, and the slave state is left untouched.
- R9: An acknowledge with no master winner returns `line_o` = 7 and vector = master base with bits 2:0 set to 7.
- R10: Bits 2:0 of each base input are ignored. A master vector is master base with bits 2:0 replaced by the line number.
- R11: A master poll returns the master winner on `poll_line_o` with `poll_done_o` one cycle later, and clears both the request and in-service bit of that line. With no winner it returns 7 and changes nothing.
- R12: A slave poll returns the slave winner in the same way, and also clears master request 2 and master in-service bit 2. With no slave winner it returns 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines_i | input | 16 | Request inputs; bits 7:0 master, 15:8 slave; bit 2 unused |
| mask_m_i | input | 8 | Master mask, 1 = blocked |
| mask_s_i | input | 8 | Slave mask, 1 = blocked |
| base_m_i | input | 8 | Master vector base (bits 2:0 ignored) |
| base_s_i | input | 8 | Slave vector base (bits 2:0 ignored) |
| ack_i | input | 1 | Acknowledge strobe (highest command priority) |
| poll_m_i | input | 1 | Master poll strobe |
| poll_s_i | input | 1 | Slave poll strobe |
| eoi_m_i | input | 1 | Master non-specific end of interrupt (only when no other command) |
| eoi_s_i | input | 1 | Slave non-specific end of interrupt (only when no other command) |
| cpu_irq_o | output | 1 | Processor interrupt request |
| vec_o | output | 8 | Vector of the last acknowledge |
| line_o | output | 4 | Global line of the last acknowledge |
| done_o | output | 1 | One-cycle pulse: acknowledge result valid |
| poll_line_o | output | 3 | Line returned by the last poll |
| poll_done_o | output | 1 | One-cycle pulse: poll result valid |

## Verification
The bench goes after the two spurious paths. In the first, a slave request is masked after it has already reached the master. A design that mixes up the fallback would return 7 or a stale slave line instead of 15 with the slave base. In the second, the master has nothing pending, and the design must return master base + 7. A second target is the cascade bookkeeping after a slave poll: a design that leaves master bit 2 in service would silently block master lines 3 to 7, which the bench shows by raising line 4 afterwards. Edge-versus-level handling is exercised by holding a serviced line high across an end of interrupt, and in-service nesting by a lower-priority line that must stay blocked until the end of interrupt.

// File: rtl/pic_cascade_pkg.sv
package pic_cascade_pkg;
    typedef enum logic [1:0] {
        CMD_NONE   = 2'd0,
        CMD_ACK    = 2'd1,
        CMD_POLL_M = 2'd2,
        CMD_POLL_S = 2'd3
    } cmd_e;
endpackage

// File: rtl/pic_prio_enc.sv
// Finds the lowest-numbered set bit (highest priority).
module pic_prio_enc #(
    parameter int N  = 8,
    parameter int LW = $clog2(N)
) (
    input  logic [N-1:0]  bits_i,
    output logic          any_o,
    output logic [LW-1:0] idx_o
);
    always_comb begin
        any_o = |bits_i;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (bits_i[i]) idx_o = LW'(i);
        end
    end
endmodule

// File: rtl/pic_resolver.sv
// One controller: request/in-service state and winner selection.
module pic_resolver #(
    parameter int N  = 8,
    parameter int LW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  edge_in_i,
    input  logic [N-1:0]  force_set_i,
    input  logic [N-1:0]  mask_i,
    input  logic          take_i,
    input  logic          drop_i,
    input  logic [LW-1:0] sel_i,
    input  logic          eoi_i,
    output logic          win_o,
    output logic [LW-1:0] win_idx_o
);
    typedef struct packed {
        logic [N-1:0] irr;
        logic [N-1:0] isr;
        logic [N-1:0] last;
    } res_st_t;

    res_st_t st_d, st_q;

    logic          pend_any, srv_any;
    logic [LW-1:0] pend_idx, srv_idx;

    pic_prio_enc #(.N(N), .LW(LW)) u_pend_enc (
        .bits_i (st_q.irr & ~mask_i),
        .any_o  (pend_any),
        .idx_o  (pend_idx)
    );

    pic_prio_enc #(.N(N), .LW(LW)) u_srv_enc (
        .bits_i (st_q.isr),
        .any_o  (srv_any),
        .idx_o  (srv_idx)
    );

    assign win_o     = pend_any && (!srv_any || (pend_idx < srv_idx));
    assign win_idx_o = pend_idx;

    always_comb begin
        logic [N-1:0] sel_bit, new_req, irr_clr, isr_set, isr_clr;
        st_d    = st_q;
        sel_bit = N'(1) << sel_i;
        new_req = (edge_in_i & ~st_q.last) | force_set_i;
        irr_clr = (take_i || drop_i) ? sel_bit : '0;
        isr_set = take_i ? sel_bit : '0;
        isr_clr = drop_i ? sel_bit : '0;
        if (eoi_i && srv_any) isr_clr = isr_clr | (N'(1) << srv_idx);
        st_d.irr  = (st_q.irr & ~irr_clr) | new_req;
        st_d.isr  = (st_q.isr | isr_set) & ~isr_clr;
        st_d.last = edge_in_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pic_ack_ctl.sv
// Command arbitration, acknowledge/poll decode and result registers.
module pic_ack_ctl
    import pic_cascade_pkg::*;
#(
    parameter int N     = 8,
    parameter int LW    = $clog2(N),
    parameter int VEC_W = 8,
    parameter int CAS   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack_i,
    input  logic             poll_m_i,
    input  logic             poll_s_i,
    input  logic             m_win_i,
    input  logic [LW-1:0]    m_idx_i,
    input  logic             s_win_i,
    input  logic [LW-1:0]    s_idx_i,
    input  logic [VEC_W-1:0] base_m_i,
    input  logic [VEC_W-1:0] base_s_i,
    output logic             m_take_o,
    output logic             m_drop_o,
    output logic [LW-1:0]    m_sel_o,
    output logic             s_take_o,
    output logic             s_drop_o,
    output logic [LW-1:0]    s_sel_o,
    output logic             cmd_busy_o,
    output logic [VEC_W-1:0] vec_o,
    output logic [LW:0]      line_o,
    output logic             done_o,
    output logic [LW-1:0]    poll_line_o,
    output logic             poll_done_o
);
    localparam logic [VEC_W-1:0] BASE_KEEP = ~VEC_W'((1 << LW) - 1);
    localparam logic [LW-1:0]    SPUR      = LW'(N - 1);
    localparam logic [LW-1:0]    CAS_IDX   = LW'(CAS);

    typedef struct packed {
        logic [VEC_W-1:0] vec;
        logic [LW:0]      line;
        logic             done;
        logic [LW-1:0]    pline;
        logic             pdone;
    } out_st_t;

    out_st_t out_d, out_q;
    cmd_e    cmd;

    always_comb begin
        if (ack_i)         cmd = CMD_ACK;
        else if (poll_m_i) cmd = CMD_POLL_M;
        else if (poll_s_i) cmd = CMD_POLL_S;
        else               cmd = CMD_NONE;
    end

    assign cmd_busy_o = (cmd != CMD_NONE);

    always_comb begin
        out_d       = out_q;
        out_d.done  = 1'b0;
        out_d.pdone = 1'b0;
        m_take_o    = 1'b0;
        m_drop_o    = 1'b0;
        m_sel_o     = m_idx_i;
        s_take_o    = 1'b0;
        s_drop_o    = 1'b0;
        s_sel_o     = s_idx_i;
        case (cmd)
            CMD_ACK: begin
                out_d.done = 1'b1;
                if (!m_win_i) begin
                    out_d.line = {1'b0, SPUR};
                    out_d.vec  = (base_m_i & BASE_KEEP) | VEC_W'(SPUR);
                end else begin
                    m_take_o = 1'b1;
                    if (m_idx_i != CAS_IDX) begin
                        out_d.line = {1'b0, m_idx_i};
                        out_d.vec  = (base_m_i & BASE_KEEP) | VEC_W'(m_idx_i);
                    end else if (s_win_i) begin
                        s_take_o   = 1'b1;
                        out_d.line = {1'b1, s_idx_i};
                        out_d.vec  = (base_s_i & BASE_KEEP) | VEC_W'(s_idx_i);
                    end else begin
                        out_d.line = {1'b1, SPUR};
                        out_d.vec  = (base_s_i & BASE_KEEP) | VEC_W'(SPUR);
                    end
                end
            end
            CMD_POLL_M: begin
                out_d.pdone = 1'b1;
                if (m_win_i) begin
                    m_drop_o    = 1'b1;
                    out_d.pline = m_idx_i;
                end else begin
                    out_d.pline = SPUR;
                end
            end
            CMD_POLL_S: begin
                out_d.pdone = 1'b1;
                if (s_win_i) begin
                    s_drop_o    = 1'b1;
                    m_drop_o    = 1'b1;
                    m_sel_o     = CAS_IDX;
                    out_d.pline = s_idx_i;
                end else begin
                    out_d.pline = SPUR;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign vec_o       = out_q.vec;
    assign line_o      = out_q.line;
    assign done_o      = out_q.done;
    assign poll_line_o = out_q.pline;
    assign poll_done_o = out_q.pdone;
endmodule

// File: rtl/pic_cascade.sv
module pic_cascade #(
    parameter int N     = 8,
    parameter int LW    = $clog2(N),
    parameter int VEC_W = 8,
    parameter int CAS   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2*N-1:0]   irq_lines_i,
    input  logic [N-1:0]     mask_m_i,
    input  logic [N-1:0]     mask_s_i,
    input  logic [VEC_W-1:0] base_m_i,
    input  logic [VEC_W-1:0] base_s_i,
    input  logic             ack_i,
    input  logic             poll_m_i,
    input  logic             poll_s_i,
    input  logic             eoi_m_i,
    input  logic             eoi_s_i,
    output logic             cpu_irq_o,
    output logic [VEC_W-1:0] vec_o,
    output logic [LW:0]      line_o,
    output logic             done_o,
    output logic [LW-1:0]    poll_line_o,
    output logic             poll_done_o
);
    localparam logic [N-1:0] CAS_BIT = N'(1) << CAS;

    logic          m_win, s_win;
    logic [LW-1:0] m_idx, s_idx, m_sel, s_sel;
    logic          m_take, m_drop, s_take, s_drop, cmd_busy;
    logic [N-1:0]  m_edges, m_force;

    // The master's own input at the cascade position is replaced by the slave.
    assign m_edges = irq_lines_i[N-1:0] & ~CAS_BIT;
    assign m_force = (s_win && !cmd_busy) ? CAS_BIT : '0;

    pic_resolver #(.N(N), .LW(LW)) u_master (
        .clk         (clk),
        .rst_n       (rst_n),
        .edge_in_i   (m_edges),
        .force_set_i (m_force),
        .mask_i      (mask_m_i),
        .take_i      (m_take),
        .drop_i      (m_drop),
        .sel_i       (m_sel),
        .eoi_i       (eoi_m_i && !cmd_busy),
        .win_o       (m_win),
        .win_idx_o   (m_idx)
    );

    pic_resolver #(.N(N), .LW(LW)) u_slave (
        .clk         (clk),
        .rst_n       (rst_n),
        .edge_in_i   (irq_lines_i[2*N-1:N]),
        .force_set_i ('0),
        .mask_i      (mask_s_i),
        .take_i      (s_take),
        .drop_i      (s_drop),
        .sel_i       (s_sel),
        .eoi_i       (eoi_s_i && !cmd_busy),
        .win_o       (s_win),
        .win_idx_o   (s_idx)
    );

    pic_ack_ctl #(.N(N), .LW(LW), .VEC_W(VEC_W), .CAS(CAS)) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .ack_i       (ack_i),
        .poll_m_i    (poll_m_i),
        .poll_s_i    (poll_s_i),
        .m_win_i     (m_win),
        .m_idx_i     (m_idx),
        .s_win_i     (s_win),
        .s_idx_i     (s_idx),
        .base_m_i    (base_m_i),
        .base_s_i    (base_s_i),
        .m_take_o    (m_take),
        .m_drop_o    (m_drop),
        .m_sel_o     (m_sel),
        .s_take_o    (s_take),
        .s_drop_o    (s_drop),
        .s_sel_o     (s_sel),
        .cmd_busy_o  (cmd_busy),
        .vec_o       (vec_o),
        .line_o      (line_o),
        .done_o      (done_o),
        .poll_line_o (poll_line_o),
        .poll_done_o (poll_done_o)
    );

    assign cpu_irq_o = m_win;
endmodule

// File: rtl/pic_cascade_chk.sv
module pic_cascade_chk #(
    parameter int N     = 8,
    parameter int LW    = $clog2(N),
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2*N-1:0]   irq_lines_i,
    input logic [N-1:0]     mask_m_i,
    input logic [N-1:0]     mask_s_i,
    input logic [VEC_W-1:0] base_m_i,
    input logic [VEC_W-1:0] base_s_i,
    input logic             ack_i,
    input logic             poll_m_i,
    input logic             poll_s_i,
    input logic             eoi_m_i,
    input logic             eoi_s_i,
    input logic             cpu_irq_o,
    input logic [VEC_W-1:0] vec_o,
    input logic [LW:0]      line_o,
    input logic             done_o,
    input logic [LW-1:0]    poll_line_o,
    input logic             poll_done_o
);
    p_done_after_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> done_o);

    p_done_needs_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(ack_i));

    p_no_cascade_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> line_o != (LW+1)'(2));

    p_master_vec_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !line_o[LW]) |->
            vec_o == {$past(base_m_i[VEC_W-1:LW]), line_o[LW-1:0]});

    p_slave_vec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && line_o[LW]) |->
            vec_o == {$past(base_s_i[VEC_W-1:LW]), line_o[LW-1:0]});

    p_spur_master_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !cpu_irq_o) |=> line_o == (LW+1)'(N - 1));

    p_poll_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
        poll_done_o |-> ($past(poll_m_i || poll_s_i) && !$past(ack_i)));
endmodule

bind pic_cascade pic_cascade_chk chk_i (.*);

// File: tb/pic_cascade_tb_top.sv
`timescale 1ns/1ps
module pic_cascade_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] lines = '0;
    logic [7:0]  mask_m = '0, mask_s = '0;
    logic [7:0]  base_m = 8'h27, base_s = 8'h7D;
    logic        ack = 0, poll_m = 0, poll_s = 0, eoi_m = 0, eoi_s = 0;
    logic        cpu_irq, done, poll_done;
    logic [7:0]  vec;
    logic [3:0]  line;
    logic [2:0]  poll_line;

    int n_chk = 0;
    int n_bad = 0;
    string cur_tag = "R1";

    always #5 clk = ~clk;

    pic_cascade dut_i (
        .clk(clk), .rst_n(rst_n), .irq_lines_i(lines),
        .mask_m_i(mask_m), .mask_s_i(mask_s),
        .base_m_i(base_m), .base_s_i(base_s),
        .ack_i(ack), .poll_m_i(poll_m), .poll_s_i(poll_s),
        .eoi_m_i(eoi_m), .eoi_s_i(eoi_s),
        .cpu_irq_o(cpu_irq), .vec_o(vec), .line_o(line), .done_o(done),
        .poll_line_o(poll_line), .poll_done_o(poll_done)
    );

    // ---------------- behavioural reference model ----------------
    bit [7:0] mirr, misr, mlast, sirr, sisr, slast;
    bit [7:0] e_vec;
    bit [3:0] e_line;
    bit       e_done, e_pdone;
    bit [2:0] e_pline;

    function automatic int lowest(bit [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return 8;
    endfunction

    function automatic int winner(bit [7:0] irr, bit [7:0] isr, bit [7:0] msk);
        int p, s;
        p = lowest(irr & ~msk);
        s = lowest(isr);
        if (p < 8 && p < s) return p;
        return -1;
    endfunction

    always @(posedge clk) begin
        int mw, sw, k;
        bit f2;
        bit [7:0] nm, ns;
        if (!rst_n) begin
            mirr = 0; misr = 0; mlast = 0; sirr = 0; sisr = 0; slast = 0;
            e_vec = 0; e_line = 0; e_done = 0; e_pdone = 0; e_pline = 0;
        end else begin
            mw = winner(mirr, misr, mask_m);
            sw = winner(sirr, sisr, mask_s);
            f2 = (sw >= 0);
            e_done = 0; e_pdone = 0;
            if (ack) begin
                e_done = 1; f2 = 0;
                if (mw < 0) begin
                    e_line = 7; e_vec = (base_m & 8'hF8) + 7;
                end else begin
                    misr[mw] = 1; mirr[mw] = 0;
                    if (mw != 2) begin
                        e_line = 4'(mw); e_vec = (base_m & 8'hF8) + 8'(mw);
                    end else if (sw >= 0) begin
                        sisr[sw] = 1; sirr[sw] = 0;
                        e_line = 4'(sw + 8); e_vec = (base_s & 8'hF8) + 8'(sw);
                    end else begin
                        e_line = 15; e_vec = (base_s & 8'hF8) + 7;
                    end
                end
            end else if (poll_m) begin
                e_pdone = 1; f2 = 0;
                if (mw >= 0) begin
                    mirr[mw] = 0; misr[mw] = 0; e_pline = 3'(mw);
                end else e_pline = 7;
            end else if (poll_s) begin
                e_pdone = 1; f2 = 0;
                if (sw >= 0) begin
                    sirr[sw] = 0; sisr[sw] = 0; mirr[2] = 0; misr[2] = 0;
                    e_pline = 3'(sw);
                end else e_pline = 7;
            end else begin
                if (eoi_m) begin k = lowest(misr); if (k < 8) misr[k] = 0; end
                if (eoi_s) begin k = lowest(sisr); if (k < 8) sisr[k] = 0; end
            end
            nm = lines[7:0];
            ns = lines[15:8];
            for (int i = 0; i < 8; i++) begin
                if (i != 2 && nm[i] && !mlast[i]) mirr[i] = 1;
                if (ns[i] && !slast[i]) sirr[i] = 1;
            end
            if (f2) mirr[2] = 1;
            mlast = nm; slast = ns;
        end
    end

    task automatic check(string tag, int got, int exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    // Every-cycle comparison against the model, tagged with the running scenario.
    always @(negedge clk) begin
        if (rst_n) begin
            check({cur_tag, " cpu_irq"}, cpu_irq, winner(mirr, misr, mask_m) >= 0);
            check({cur_tag, " done"}, done, e_done);
            check({cur_tag, " vec"}, vec, e_vec);
            check({cur_tag, " line"}, line, e_line);
            check({cur_tag, " poll_done"}, poll_done, e_pdone);
            check({cur_tag, " poll_line"}, poll_line, e_pline);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_line(int i, logic v);
        @(negedge clk); #1 lines[i] = v;
    endtask

    task automatic do_ack(string tag, int exp_line, int exp_vec);
        @(negedge clk); #1 ack = 1;
        @(negedge clk);
        check({tag, " ack done"}, done, 1);
        check({tag, " ack line"}, line, exp_line);
        check({tag, " ack vec"}, vec, exp_vec);
        #1 ack = 0;
    endtask

    task automatic do_poll(string tag, bit slave, int exp_line);
        @(negedge clk); #1 if (slave) poll_s = 1; else poll_m = 1;
        @(negedge clk);
        check({tag, " poll done"}, poll_done, 1);
        check({tag, " poll line"}, poll_line, exp_line);
        #1 poll_s = 0; poll_m = 0;
    endtask

    task automatic do_eoi(bit m, bit s);
        @(negedge clk); #1 eoi_m = m; eoi_s = s;
        @(negedge clk); #1 eoi_m = 0; eoi_s = 0;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(200000 * 10);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // ---------------- scenarios ----------------
    initial begin
        idle(3);
        #1 rst_n = 1;
        @(negedge clk);
        cur_tag = "R1";
        check("R1 reset cpu_irq", cpu_irq, 0);
        check("R1 reset done", done, 0);
        check("R1 reset vec", vec, 0);
        check("R1 reset line", line, 0);
        check("R1 reset poll_done", poll_done, 0);

        // Master line 5, base low bits ignored, held level does not retrigger.
        cur_tag = "R6";
        set_line(5, 1); idle(2);
        check("R5 irq from master", cpu_irq, 1);
        do_ack("R6 R10", 5, 8'h25);
        idle(1);
        check("R6 irq drops after ack", cpu_irq, 0);
        cur_tag = "R2";
        do_eoi(1, 0); idle(2);
        check("R2 held line no retrigger", cpu_irq, 0);
        set_line(5, 0);

        // Fixed priority and in-service nesting.
        cur_tag = "R3";
        @(negedge clk); #1 lines[6] = 1; lines[1] = 1;
        idle(2);
        do_ack("R3 high prio", 1, 8'h21);
        idle(1);
        check("R3 lower blocked by isr", cpu_irq, 0);
        do_eoi(1, 0);
        check("R3 unblocked after eoi", cpu_irq, 1);
        do_ack("R3 second", 6, 8'h26);
        do_eoi(1, 0);
        @(negedge clk); #1 lines[6] = 0; lines[1] = 0;

        // Mask.
        cur_tag = "R4";
        @(negedge clk); #1 mask_m = 8'h08;
        set_line(3, 1); idle(3);
        check("R4 masked no irq", cpu_irq, 0);
        @(negedge clk); #1 mask_m = 8'h00;
        idle(1);
        check("R4 unmasked irq", cpu_irq, 1);
        do_ack("R4", 3, 8'h23);
        do_eoi(1, 0);
        set_line(3, 0);

        // External line 2 ignored.
        cur_tag = "R5";
        set_line(2, 1); idle(3);
        check("R5 line2 ignored", cpu_irq, 0);
        set_line(2, 0);

        // Slave acknowledge.
        cur_tag = "R7";
        set_line(11, 1); idle(1);
        check("R5 slave needs extra cycle", cpu_irq, 0);
        idle(1);
        check("R5 slave reaches master", cpu_irq, 1);
        do_ack("R7", 11, 8'h7B);
        do_eoi(1, 1);
        set_line(11, 0);

        // Spurious on slave.
        cur_tag = "R8";
        set_line(14, 1); idle(3);
        @(negedge clk); #1 mask_s = 8'h40;
        idle(2);
        check("R8 master still pending", cpu_irq, 1);
        do_ack("R8 spurious slave", 15, 8'h7F);
        do_eoi(1, 0);
        @(negedge clk); #1 mask_s = 8'h00;
        idle(3);
        check("R8 slave request kept", cpu_irq, 1);
        do_ack("R8 later real", 14, 8'h7E);
        do_eoi(1, 1);
        set_line(14, 0);

        // Spurious on master.
        cur_tag = "R9";
        idle(2);
        do_ack("R9 spurious master", 7, 8'h27);

        // Master poll.
        cur_tag = "R11";
        set_line(3, 1); idle(2);
        do_poll("R11 master", 0, 3);
        idle(1);
        check("R11 irq cleared", cpu_irq, 0);
        set_line(5, 1); idle(2);
        check("R11 isr cleared so 5 wins", cpu_irq, 1);
        do_poll("R11 master 5", 0, 5);
        do_poll("R11 none", 0, 7);
        @(negedge clk); #1 lines[3] = 0; lines[5] = 0;

        // Slave poll.
        cur_tag = "R12";
        set_line(10, 1); idle(3);
        check("R12 cascaded irq", cpu_irq, 1);
        do_poll("R12 slave", 1, 2);
        idle(2);
        check("R12 master bit2 cleared", cpu_irq, 0);
        set_line(4, 1); idle(2);
        check("R12 master isr2 clear", cpu_irq, 1);
        do_poll("R12 master after", 0, 4);
        do_poll("R12 slave none", 1, 7);
        @(negedge clk); #1 lines[10] = 0; lines[4] = 0;
        idle(3);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule